// File: doc/BRIEF.md
# Two-Way Conditional Dispatch and Rejoin

This block sits at the point in a streaming datapath where a context word must go down one of two alternative processing paths. Each incoming context carries a data payload and a decision bit that was computed upstream. The block hands the payload to the "then" path when the bit is set and to the "else" path when it is clear. It then collects the finished payloads from both paths into one output stream. The two paths live outside the block. Each path connects through an outbound port (send) and an inbound port (return), and every port uses a valid/ready handshake.

A static mode input chooses how results are rejoined. With ordering enabled, a small queue records the path each accepted context took. The rejoin stage then always serves the path at the head of that queue, so results leave in arrival order even when the two paths have very different latencies. With ordering disabled, the queue is bypassed and the rejoin stage takes whichever path has a result, preferring the "then" path on a tie. Results may then be reordered. The mode is expected to change only while no context is in flight.

Top module: `cond_fork_merge`

## Requirements
- R1: A context accepted with `in_cond`=1 is sent to the then path, and one with `in_cond`=0 is sent to the else path, with the payload unchanged. The block never offers valid on both send ports in the same cycle.
- R2: `in_ready` is high only when the path named by `in_cond` is ready (and, in ordered mode, the decision queue has room). While the chosen path is not ready, the send valid of the other path stays low.
- R3: In ordered mode (`keep_order`=1), results leave `out_data` in the order their contexts were accepted, whatever the path latencies.
- R4: In ordered mode, the rejoin stage waits for the path recorded at the head of the decision queue. `out_valid` stays low while only the other path holds a result.
- R5: The decision queue holds 8 entries. In ordered mode, with 8 accepted contexts not yet rejoined, `in_ready` is low. Acceptance resumes once a result is rejoined.
- R6: In unordered mode (`keep_order`=0), a result is forwarded as soon as either path presents it. A later context on a fast path may therefore overtake an earlier one on a slow path.
- R7: In unordered mode, when both return ports are valid in the same cycle, the then path is served first.
- R8: The output is registered. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. At most one return port completes a handshake per cycle.
- R9: After reset, `out_valid` is low, the decision queue is empty, and `in_ready` follows the chosen path's ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| keep_order | input | 1 | 1: rejoin in arrival order; 0: serve whichever path is ready |
| in_valid | input | 1 | Incoming context valid |
| in_ready | output | 1 | Incoming context accepted |
| in_data | input | DATA_W | Context payload |
| in_cond | input | 1 | Precomputed decision: 1 then path, 0 else path |
| then_tx_valid | output | 1 | Send to then path valid |
| then_tx_ready | input | 1 | Then path can accept |
| then_tx_data | output | DATA_W | Payload to then path |
| then_rx_valid | input | 1 | Then path result valid |
| then_rx_ready | output | 1 | Then path result taken |
| then_rx_data | input | DATA_W | Then path result |
| else_tx_valid | output | 1 | Send to else path valid |
| else_tx_ready | input | 1 | Else path can accept |
| else_tx_data | output | DATA_W | Payload to else path |
| else_rx_valid | input | 1 | Else path result valid |
| else_rx_ready | output | 1 | Else path result taken |
| else_rx_data | input | DATA_W | Else path result |
| out_valid | output | 1 | Rejoined result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_data | output | DATA_W | Rejoined result |

## Verification
The bench models the two paths with unequal latencies (short for then, long for else), each applying a distinct transform. An output can therefore only match its expected value if it was routed to the correct path. Random decision streams with random output backpressure are run in both modes: ordered runs are compared strictly in arrival order, and unordered runs by membership. Directed patterns separate the modes. A slow-then-fast pair is checked twice: in ordered mode it must come out in arrival order with `out_valid` held low while the wrong path waits, and in unordered mode it must come out overtaken. Further patterns are two results released in the same cycle (then first), nine contexts against held paths (the ninth stalls), a send path that refuses, and a stalled output that must hold.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  typedef enum logic {
    BR_ELSE = 1'b0,
    BR_THEN = 1'b1
  } branch_e;
endpackage

// File: rtl/cfm_tag_fifo.sv
// Decision queue: one entry per accepted context in ordered mode.
// DEPTH must be a power of two, at least 2.
module cfm_tag_fifo
  import cfm_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    push,
  input  branch_e push_tag,
  input  logic    pop,
  output branch_e head_tag,
  output logic    empty,
  output logic    full
);
  localparam int AW = $clog2(DEPTH);

  branch_e       mem [DEPTH];
  logic [AW:0]   wr_q, rd_q;

  assign empty    = (wr_q == rd_q);
  assign full     = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign head_tag = mem[rd_q[AW-1:0]];

  // storage has no reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_q[AW-1:0]] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push && !full) wr_q <= wr_q + 1'b1;
      if (pop && !empty) rd_q <= rd_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfm_fork.sv
// Dispatch: one context goes to exactly one path, only when both the
// chosen path and the decision queue accept in the same cycle.
module cfm_fork
  import cfm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_cond,
  input  logic              tag_room,
  output logic              in_ready,
  output logic              accept,
  output branch_e           accept_tag,
  output logic              then_tx_valid,
  input  logic              then_tx_ready,
  output logic [DATA_W-1:0] then_tx_data,
  output logic              else_tx_valid,
  input  logic              else_tx_ready,
  output logic [DATA_W-1:0] else_tx_data
);
  branch_e sel;

  always_comb begin
    sel           = in_cond ? BR_THEN : BR_ELSE;
    then_tx_valid = in_valid && tag_room && (sel == BR_THEN);
    else_tx_valid = in_valid && tag_room && (sel == BR_ELSE);
    in_ready      = tag_room && ((sel == BR_THEN) ? then_tx_ready : else_tx_ready);
    accept        = in_valid && in_ready;
    accept_tag    = sel;
  end

  assign then_tx_data = in_data;
  assign else_tx_data = in_data;
endmodule

// File: rtl/cfm_merge.sv
// Rejoin: picks one return port per cycle into a registered output.
module cfm_merge
  import cfm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              keep_order,
  input  logic              head_valid,
  input  branch_e           head_tag,
  input  logic              then_rx_valid,
  output logic              then_rx_ready,
  input  logic [DATA_W-1:0] then_rx_data,
  input  logic              else_rx_valid,
  output logic              else_rx_ready,
  input  logic [DATA_W-1:0] else_rx_data,
  output logic              pop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              load, take_then, take_else;

  assign load = !valid_q || out_ready;

  always_comb begin
    if (keep_order) begin
      then_rx_ready = load && head_valid && (head_tag == BR_THEN);
      else_rx_ready = load && head_valid && (head_tag == BR_ELSE);
    end else begin
      then_rx_ready = load;
      else_rx_ready = load && !then_rx_valid;
    end
    take_then = then_rx_valid && then_rx_ready;
    take_else = else_rx_valid && else_rx_ready;
    pop       = keep_order && (take_then || take_else);
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else if (load) valid_q <= take_then || take_else;
  end

  always_ff @(posedge clk) begin
    if (take_then) data_q <= then_rx_data;
    else if (take_else) data_q <= else_rx_data;
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
endmodule

// File: rtl/cond_fork_merge.sv
module cond_fork_merge
  import cfm_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int TAG_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              keep_order,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_cond,
  output logic              then_tx_valid,
  input  logic              then_tx_ready,
  output logic [DATA_W-1:0] then_tx_data,
  input  logic              then_rx_valid,
  output logic              then_rx_ready,
  input  logic [DATA_W-1:0] then_rx_data,
  output logic              else_tx_valid,
  input  logic              else_tx_ready,
  output logic [DATA_W-1:0] else_tx_data,
  input  logic              else_rx_valid,
  output logic              else_rx_ready,
  input  logic [DATA_W-1:0] else_rx_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic    tag_room, accept, tag_push, tag_pop, tag_empty, tag_full;
  branch_e accept_tag, head_tag;

  assign tag_room = !keep_order || !tag_full;
  assign tag_push = keep_order && accept;

  cfm_fork #(.DATA_W(DATA_W)) u_fork (
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_cond      (in_cond),
    .tag_room     (tag_room),
    .in_ready     (in_ready),
    .accept       (accept),
    .accept_tag   (accept_tag),
    .then_tx_valid(then_tx_valid),
    .then_tx_ready(then_tx_ready),
    .then_tx_data (then_tx_data),
    .else_tx_valid(else_tx_valid),
    .else_tx_ready(else_tx_ready),
    .else_tx_data (else_tx_data)
  );

  cfm_tag_fifo #(.DEPTH(TAG_DEPTH)) u_tags (
    .clk     (clk),
    .rst     (rst),
    .push    (tag_push),
    .push_tag(accept_tag),
    .pop     (tag_pop),
    .head_tag(head_tag),
    .empty   (tag_empty),
    .full    (tag_full)
  );

  cfm_merge #(.DATA_W(DATA_W)) u_merge (
    .clk          (clk),
    .rst          (rst),
    .keep_order   (keep_order),
    .head_valid   (!tag_empty),
    .head_tag     (head_tag),
    .then_rx_valid(then_rx_valid),
    .then_rx_ready(then_rx_ready),
    .then_rx_data (then_rx_data),
    .else_rx_valid(else_rx_valid),
    .else_rx_ready(else_rx_ready),
    .else_rx_data (else_rx_data),
    .pop          (tag_pop),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data)
  );
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker
  import cfm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              keep_order,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_cond,
  input logic              then_tx_valid,
  input logic              then_tx_ready,
  input logic              else_tx_valid,
  input logic              else_tx_ready,
  input logic              then_rx_valid,
  input logic              then_rx_ready,
  input logic              else_rx_valid,
  input logic              else_rx_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              tag_full,
  input logic              tag_empty,
  input branch_e           head_tag
);
  assert_one_path_R1: assert property (@(posedge clk) disable iff (rst)
    !(then_tx_valid && else_tx_valid));

  assert_routed_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |->
      (in_cond ? (then_tx_valid && then_tx_ready) : (else_tx_valid && else_tx_ready)));

  assert_full_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (keep_order && tag_full) |-> !in_ready);

  assert_head_then_R4: assert property (@(posedge clk) disable iff (rst)
    (keep_order && then_rx_ready) |-> (!tag_empty && head_tag == BR_THEN));

  assert_head_else_R4: assert property (@(posedge clk) disable iff (rst)
    (keep_order && else_rx_ready) |-> (!tag_empty && head_tag == BR_ELSE));

  assert_then_first_R7: assert property (@(posedge clk) disable iff (rst)
    (!keep_order && then_rx_valid && else_rx_valid) |-> !else_rx_ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_single_take_R8: assert property (@(posedge clk) disable iff (rst)
    !(then_rx_valid && then_rx_ready && else_rx_valid && else_rx_ready));
endmodule

bind cond_fork_merge cfm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .keep_order   (keep_order),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_cond      (in_cond),
  .then_tx_valid(then_tx_valid),
  .then_tx_ready(then_tx_ready),
  .else_tx_valid(else_tx_valid),
  .else_tx_ready(else_tx_ready),
  .then_rx_valid(then_rx_valid),
  .then_rx_ready(then_rx_ready),
  .else_rx_valid(else_rx_valid),
  .else_rx_ready(else_rx_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .tag_full     (tag_full),
  .tag_empty    (tag_empty),
  .head_tag     (head_tag)
);

// File: tb/cond_fork_merge_tb.sv
`timescale 1ns/1ps
module cond_fork_merge_tb;
  localparam int DW    = 16;
  localparam int LAT_T = 2;
  localparam int LAT_E = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          keep_order = 1'b1;
  logic          in_valid = 1'b0, in_cond = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic          then_tx_valid, else_tx_valid, then_rx_ready, else_rx_ready, out_valid;
  logic [DW-1:0] then_tx_data, else_tx_data, out_data;
  logic          t_acc = 1'b1, e_acc = 1'b1;
  logic          hold_t = 1'b0, hold_e = 1'b0;
  logic          t_head_ok = 1'b0, e_head_ok = 1'b0;
  logic [DW-1:0] t_head_v = '0, e_head_v = '0;
  logic          then_rx_valid, else_rx_valid, out_ready;
  logic          bp_en = 1'b0, stall_out = 1'b0;
  logic [7:0]    lfsr = 8'h5B;

  assign then_rx_valid = t_head_ok && !hold_t;
  assign else_rx_valid = e_head_ok && !hold_e;
  assign out_ready     = stall_out ? 1'b0 : (bp_en ? lfsr[0] : 1'b1);

  cond_fork_merge #(.DATA_W(DW), .TAG_DEPTH(8)) u_dut (
    .clk(clk), .rst(rst), .keep_order(keep_order),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_cond(in_cond),
    .then_tx_valid(then_tx_valid), .then_tx_ready(t_acc), .then_tx_data(then_tx_data),
    .then_rx_valid(then_rx_valid), .then_rx_ready(then_rx_ready), .then_rx_data(t_head_v),
    .else_tx_valid(else_tx_valid), .else_tx_ready(e_acc), .else_tx_data(else_tx_data),
    .else_rx_valid(else_rx_valid), .else_rx_ready(else_rx_ready), .else_rx_data(e_head_v),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // handshakes captured at the edge, applied at the following falling edge
  logic t_in_f, e_in_f, t_out_f, e_out_f, o_f;
  logic [DW-1:0] t_in_d, e_in_d, o_d;
  always @(posedge clk) begin
    cyc     <= cyc + 1;
    t_in_f  <= then_tx_valid && t_acc;
    e_in_f  <= else_tx_valid && e_acc;
    t_in_d  <= then_tx_data;
    e_in_d  <= else_tx_data;
    t_out_f <= then_rx_valid && then_rx_ready;
    e_out_f <= else_rx_valid && else_rx_ready;
    o_f     <= out_valid && out_ready;
    o_d     <= out_data;
  end

  // path models: then = xor 5A00 after LAT_T, else = invert after LAT_E
  logic [DW-1:0] tq_v[$], eq_v[$];
  int            tq_d[$], eq_d[$];
  always @(negedge clk) begin
    if (rst) begin
      tq_v.delete(); tq_d.delete(); eq_v.delete(); eq_d.delete();
    end else begin
      if (t_out_f) begin void'(tq_v.pop_front()); void'(tq_d.pop_front()); end
      if (e_out_f) begin void'(eq_v.pop_front()); void'(eq_d.pop_front()); end
      if (t_in_f) begin tq_v.push_back(t_in_d ^ 16'h5A00); tq_d.push_back(cyc + LAT_T); end
      if (e_in_f) begin eq_v.push_back(~e_in_d); eq_d.push_back(cyc + LAT_E); end
    end
    t_head_ok = (tq_v.size() > 0) && (tq_d[0] <= cyc);
    e_head_ok = (eq_v.size() > 0) && (eq_d[0] <= cyc);
    t_head_v  = (tq_v.size() > 0) ? tq_v[0] : '0;
    e_head_v  = (eq_v.size() > 0) ? eq_v[0] : '0;
    lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  // scoreboard
  logic [DW-1:0] exp_q[$];
  string         req_q[$];
  bit            search_mode = 0;

  function automatic logic [DW-1:0] model(input logic [DW-1:0] d, input logic c);
    return c ? (d ^ 16'h5A00) : ~d;
  endfunction

  always @(negedge clk) begin
    if (!rst && o_f) begin
      if (exp_q.size() == 0) begin
        check(0, "R3 unexpected output", o_d, '0);
      end else if (search_mode) begin
        int idx = -1;
        foreach (exp_q[i]) if (idx < 0 && exp_q[i] === o_d) idx = i;
        check(idx >= 0, "R6 output not in expected set", o_d, exp_q[0]);
        if (idx >= 0) begin exp_q.delete(idx); req_q.delete(idx); end
      end else begin
        check(o_d === exp_q[0], req_q[0], o_d, exp_q[0]);
        void'(exp_q.pop_front());
        void'(req_q.pop_front());
      end
    end
  end

  task automatic expect_item(input logic [DW-1:0] v, input string req);
    exp_q.push_back(v);
    req_q.push_back(req);
  endtask

  task automatic send(input logic [DW-1:0] d, input logic c, input bit push_exp,
                      input string req);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_cond = c;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    if (push_exp) expect_item(model(d, c), req);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 600) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, req, DW'(exp_q.size()), '0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    // R9: reset state
    check(out_valid == 1'b0, "R9 out_valid after reset", DW'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready after reset", DW'(in_ready), 1);

    // R2 / R1: chosen path refuses
    t_acc = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_cond = 1'b1; in_data = 16'h1234;
    #1;
    check(in_ready == 1'b0, "R2 stall when then path busy", DW'(in_ready), 0);
    check(else_tx_valid == 1'b0, "R2 no offer on else path", DW'(else_tx_valid), 0);
    check(then_tx_valid == 1'b1, "R1 offer on then path", DW'(then_tx_valid), 1);
    check(then_tx_data == 16'h1234, "R1 payload unchanged", then_tx_data, 16'h1234);
    t_acc = 1'b1;
    #0.5;
    check(in_ready == 1'b1, "R2 accept once path ready", DW'(in_ready), 1);
    @(posedge clk);
    expect_item(model(16'h1234, 1'b1), "R1 then routing");
    #1 in_valid = 1'b0;
    send(16'h00C3, 1'b0, 1, "R1 else routing");
    drain("R1 drain");

    // R4: ordered, slow head blocks a ready then result
    keep_order = 1'b1;
    hold_e = 1'b1;
    send(16'hAAAA, 1'b0, 1, "R3 ordered head");
    send(16'hBBBB, 1'b1, 1, "R3 ordered follower");
    repeat (6) @(negedge clk);
    #1;
    check(then_rx_valid == 1'b1, "R4 then result pending", DW'(then_rx_valid), 1);
    check(out_valid == 1'b0, "R4 waits for named path", DW'(out_valid), 0);
    hold_e = 1'b0;
    drain("R4 drain");

    // R5: decision queue capacity
    hold_t = 1'b1; hold_e = 1'b1;
    for (int i = 0; i < 8; i++) send(DW'(16'h0100 + i), i[0], 1, "R5 order across full queue");
    @(negedge clk);
    in_valid = 1'b1; in_cond = 1'b1; in_data = 16'h0999;
    #1;
    check(in_ready == 1'b0, "R5 ninth context stalls", DW'(in_ready), 0);
    in_valid = 1'b0;
    hold_t = 1'b0; hold_e = 1'b0;
    send(16'h0999, 1'b1, 1, "R5 ninth after release");
    drain("R5 drain");

    // R8: held output
    stall_out = 1'b1;
    send(16'h7777, 1'b1, 1, "R8 held value delivered");
    repeat (LAT_T + 4) @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R8 valid while stalled", DW'(out_valid), 1);
    check(out_data == model(16'h7777, 1'b1), "R8 data while stalled", out_data,
          model(16'h7777, 1'b1));
    repeat (3) @(negedge clk);
    #1;
    check(out_data == model(16'h7777, 1'b1), "R8 data stable", out_data,
          model(16'h7777, 1'b1));
    stall_out = 1'b0;
    drain("R8 drain");

    // R3: ordered random stream with backpressure
    bp_en = 1'b1;
    for (int i = 0; i < 60; i++) send(DW'($urandom), 1'($urandom), 1, "R3 arrival order");
    drain("R3 drain");
    bp_en = 1'b0;

    // R6: unordered, fast later context overtakes
    keep_order = 1'b0;
    send(16'h4444, 1'b0, 0, "");
    send(16'h5555, 1'b1, 0, "");
    expect_item(model(16'h5555, 1'b1), "R6 fast path overtakes");
    expect_item(model(16'h4444, 1'b0), "R6 slow path follows");
    drain("R6 drain");

    // R7: simultaneous results, then first
    hold_t = 1'b1; hold_e = 1'b1;
    send(16'h6666, 1'b0, 0, "");
    send(16'h8888, 1'b1, 0, "");
    repeat (LAT_E + 3) @(negedge clk);
    expect_item(model(16'h8888, 1'b1), "R7 then served first");
    expect_item(model(16'h6666, 1'b0), "R7 else served second");
    #1 hold_t = 1'b0; hold_e = 1'b0;
    drain("R7 drain");

    // R6: unordered random stream, membership check
    search_mode = 1;
    bp_en = 1'b1;
    for (int i = 0; i < 60; i++) send(DW'($urandom), 1'($urandom), 1, "R6 membership");
    drain("R6 random drain");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule